// File: doc/BRIEF.md
# Framed Parallel Receive Channel

This block is the receive side of a 16-bit source-synchronous parallel link. The link has a line-start strobe, a data-valid strobe and a data bus. Every input is taken on the rising edge of the link clock. Software arms the channel with a receive window, given as a number of lines and a line length in bytes. The channel then keeps each qualified word in an internal buffer and raises a sticky completion interrupt when the last byte of the last line has arrived. At that point it disarms itself.

A word is qualified only when the channel is armed, the data-valid strobe is high, and either the line-start strobe is high or a line is already open. Words that arrive while the channel is unarmed, or between lines without a line start, are discarded. This keeps stale traffic out of the next window. The discard is recorded in a sticky overrun flag. A line start that arrives inside an open line rewinds that line to its first buffer slot and records a framing error. Software reads stored words through a combinational read port. The flow-control output is held low, because the buffer holds a full window.

Top module: `pbus_rx_window`

## Requirements
- R1: After reset, `irq`, `armed`, `err_ovr`, `err_frm`, `rx_words` and `bus_wait` are all zero.
- R2: A control write to address 0 loads the line count from `ctl_wdata[31:16]` and the line length in bytes from `ctl_wdata[15:0]`. On the next cycle `armed` is 1 and `rx_words` is 0.
- R3: A qualified word is stored at the next buffer index and increments `rx_words` on the same clock edge. A qualified word is `armed`, `bus_enable` high, and either `bus_start` high or a line already open. The word then reads back on `rd_data` at that index.
- R4: Clocks with `bus_enable` low change neither `rx_words` nor the buffer, even when `bus_start` is high.
- R5: On the edge that takes the final word of the final line, `irq` becomes 1 and `armed` becomes 0. Each word counts 2 bytes toward the line length.
- R6: `irq` stays 1 until a control write to address 1 with bit 0 set. A write to address 1 with bit 0 clear leaves it at 1.
- R7: A word with `bus_enable` high while unarmed is dropped and sets `err_ovr`. `rx_words` does not change. A window armed afterwards starts at index 0 with the new data.
- R8: A word with `bus_enable` high while armed but with no open line and no `bus_start` is dropped and sets `err_ovr`.
- R9: A `bus_start` inside an open line sets `err_frm`. The line then restarts at its first buffer index, the new word is stored there, and the line's byte count restarts from that word.
- R10: A window of several lines completes only after the configured number of lines. Between lines, the channel waits for a new `bus_start`.
- R11: A control write to address 1 with bit 1 set clears `err_ovr` and `err_frm`.
- R12: `bus_wait` is always 0.
- R13: Qualified words beyond the buffer capacity are not stored and set `err_ovr`. They still count toward the line length, so the window still completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Control write strobe |
| ctl_addr | input | 2 | Control register address (0 arm, 1 clear) |
| ctl_wdata | input | 32 | Control write data |
| bus_start | input | 1 | Line-start strobe |
| bus_enable | input | 1 | Data-valid strobe |
| bus_data | input | DATA_W | Link data word |
| bus_wait | output | 1 | Flow-control back-pressure, held low |
| rd_addr | input | AW | Buffer read index |
| rd_data | output | DATA_W | Word stored at `rd_addr` |
| rx_words | output | AW+1 | Words stored in the current window |
| armed | output | 1 | Channel armed and collecting |
| irq | output | 1 | Sticky window-complete interrupt |
| err_ovr | output | 1 | Sticky dropped-word flag |
| err_frm | output | 1 | Sticky mid-line start flag |

## Verification
The bench first targets the failure where words from before arming leak into a window. If a design carried them over, the re-armed window would read back old data at index 0, or it would complete one window late. The bench also sends idle clocks and start-without-valid clocks between words. A design that qualified on `bus_start` alone would store extra words and finish early. A mid-line restart is driven to catch a design that appends instead of rewinding: such a design would show the wrong word at the line's first index. Finally, an oversized window checks that the capacity drop still completes the window rather than hanging armed.

// File: rtl/pbus_rx_pkg.sv
package pbus_rx_pkg;
   localparam int CTL_AW = 2;
   localparam int CTL_DW = 32;
   localparam int CNT_W  = 16;

   localparam logic [CTL_AW-1:0] ADDR_ARM = 2'd0;
   localparam logic [CTL_AW-1:0] ADDR_CLR = 2'd1;
   localparam int CLR_IRQ_BIT = 0;
   localparam int CLR_ERR_BIT = 1;

   typedef struct packed {
      logic [CNT_W-1:0] lines;
      logic [CNT_W-1:0] bytes;
   } win_cfg_t;
endpackage

// File: rtl/pbus_rx_ctl.sv
module pbus_rx_ctl
   import pbus_rx_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_wr,
   input  logic [CTL_AW-1:0] ctl_addr,
   input  logic [CTL_DW-1:0] ctl_wdata,
   input  logic              done_evt,
   input  logic              ovr_evt,
   input  logic              frm_evt,
   output logic              arm,
   output win_cfg_t          cfg,
   output logic              irq,
   output logic              err_ovr,
   output logic              err_frm
);
   logic clr_wr, clr_irq, clr_err;

   assign arm     = ctl_wr && (ctl_addr == ADDR_ARM);
   assign clr_wr  = ctl_wr && (ctl_addr == ADDR_CLR);
   assign clr_irq = clr_wr && ctl_wdata[CLR_IRQ_BIT];
   assign clr_err = clr_wr && ctl_wdata[CLR_ERR_BIT];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg     <= '0;
         irq     <= 1'b0;
         err_ovr <= 1'b0;
         err_frm <= 1'b0;
      end else begin
         if (arm) cfg <= win_cfg_t'(ctl_wdata);
         if (done_evt)     irq <= 1'b1;
         else if (clr_irq) irq <= 1'b0;
         if (ovr_evt)      err_ovr <= 1'b1;
         else if (clr_err) err_ovr <= 1'b0;
         if (frm_evt)      err_frm <= 1'b1;
         else if (clr_err) err_frm <= 1'b0;
      end
   end
endmodule

// File: rtl/pbus_rx_framer.sv
module pbus_rx_framer
   import pbus_rx_pkg::*;
#(
   parameter  int DATA_W    = 16,
   parameter  int BUF_WORDS = 64,
   localparam int AW        = $clog2(BUF_WORDS),
   localparam int BPW       = DATA_W / 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          arm,
   input  win_cfg_t      cfg,
   input  logic          bus_start,
   input  logic          bus_enable,
   output logic          armed,
   output logic          we,
   output logic [AW-1:0] waddr,
   output logic [AW:0]   words,
   output logic          done_evt,
   output logic          ovr_evt,
   output logic          frm_evt
);
   localparam logic [AW:0]    DEPTH_V = (AW+1)'(BUF_WORDS);
   localparam logic [CNT_W:0] BPW_V   = (CNT_W+1)'(BPW);

   logic             in_line;
   logic [CNT_W:0]   line_cnt, lines_done;
   logic [AW:0]      wptr, line_base;

   logic             open_ok, qual, restart, room, line_end, last;
   logic [AW:0]      idx;
   logic [CNT_W:0]   bytes_now, lines_next;

   always_comb begin
      open_ok    = armed && (bus_start || in_line);
      qual       = bus_enable && open_ok;
      restart    = qual && bus_start && in_line;
      idx        = restart ? line_base : wptr;
      room       = idx < DEPTH_V;
      bytes_now  = (bus_start ? '0 : line_cnt) + BPW_V;
      line_end   = bytes_now >= {1'b0, cfg.bytes};
      lines_next = lines_done + 1'b1;
      last       = line_end && (lines_next >= {1'b0, cfg.lines});
   end

   assign we       = qual && room && !arm;
   assign waddr    = idx[AW-1:0];
   assign words    = wptr;
   assign done_evt = qual && last && !arm;
   assign frm_evt  = restart && !arm;
   assign ovr_evt  = !arm && bus_enable && (!open_ok || !room);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed      <= 1'b0;
         in_line    <= 1'b0;
         line_cnt   <= '0;
         lines_done <= '0;
         wptr       <= '0;
         line_base  <= '0;
      end else if (arm) begin
         armed      <= 1'b1;
         in_line    <= 1'b0;
         line_cnt   <= '0;
         lines_done <= '0;
         wptr       <= '0;
         line_base  <= '0;
      end else if (qual) begin
         if (bus_start) line_base <= idx;
         wptr <= room ? idx + 1'b1 : idx;
         if (line_end) begin
            in_line    <= 1'b0;
            line_cnt   <= '0;
            lines_done <= lines_next;
            if (last) armed <= 1'b0;
         end else begin
            in_line  <= 1'b1;
            line_cnt <= bytes_now;
         end
      end
   end
endmodule

// File: rtl/pbus_rx_buf.sv
module pbus_rx_buf #(
   parameter  int DATA_W    = 16,
   parameter  int BUF_WORDS = 64,
   parameter  bit RD_REG    = 1'b0,
   localparam int AW        = $clog2(BUF_WORDS)
) (
   input  logic              clk,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [AW-1:0]     raddr,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] mem [BUF_WORDS];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   generate
      if (RD_REG) begin : g_rd_reg
         always_ff @(posedge clk) rdata <= mem[raddr];
      end else begin : g_rd_comb
         assign rdata = mem[raddr];
      end
   endgenerate
endmodule

// File: rtl/pbus_rx_window.sv
module pbus_rx_window
   import pbus_rx_pkg::*;
#(
   parameter  int DATA_W    = 16,
   parameter  int BUF_WORDS = 64,
   localparam int AW        = $clog2(BUF_WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_wr,
   input  logic [1:0]        ctl_addr,
   input  logic [31:0]       ctl_wdata,
   input  logic              bus_start,
   input  logic              bus_enable,
   input  logic [DATA_W-1:0] bus_data,
   output logic              bus_wait,
   input  logic [AW-1:0]     rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic [AW:0]       rx_words,
   output logic              armed,
   output logic              irq,
   output logic              err_ovr,
   output logic              err_frm
);
   generate
      if (DATA_W % 8 != 0 || DATA_W < 8) begin : g_bad_width
         $error("DATA_W must be a whole number of bytes");
      end
      if (BUF_WORDS < 2 || (BUF_WORDS & (BUF_WORDS - 1)) != 0) begin : g_bad_depth
         $error("BUF_WORDS must be a power of two of at least 2");
      end
   endgenerate

   logic          arm, done_evt, ovr_evt, frm_evt, we;
   logic [AW-1:0] waddr;
   win_cfg_t      cfg;

   assign bus_wait = 1'b0;

   pbus_rx_ctl u_ctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctl_wr    (ctl_wr),
      .ctl_addr  (ctl_addr),
      .ctl_wdata (ctl_wdata),
      .done_evt  (done_evt),
      .ovr_evt   (ovr_evt),
      .frm_evt   (frm_evt),
      .arm       (arm),
      .cfg       (cfg),
      .irq       (irq),
      .err_ovr   (err_ovr),
      .err_frm   (err_frm)
   );

   pbus_rx_framer #(.DATA_W(DATA_W), .BUF_WORDS(BUF_WORDS)) u_framer (
      .clk        (clk),
      .rst_n      (rst_n),
      .arm        (arm),
      .cfg        (cfg),
      .bus_start  (bus_start),
      .bus_enable (bus_enable),
      .armed      (armed),
      .we         (we),
      .waddr      (waddr),
      .words      (rx_words),
      .done_evt   (done_evt),
      .ovr_evt    (ovr_evt),
      .frm_evt    (frm_evt)
   );

   pbus_rx_buf #(.DATA_W(DATA_W), .BUF_WORDS(BUF_WORDS), .RD_REG(1'b0)) u_buf (
      .clk   (clk),
      .we    (we),
      .waddr (waddr),
      .wdata (bus_data),
      .raddr (rd_addr),
      .rdata (rd_data)
   );
endmodule

// File: rtl/pbus_rx_chk.sv
module pbus_rx_chk #(
   parameter  int BUF_WORDS = 64,
   localparam int AW        = $clog2(BUF_WORDS)
) (
   input logic        clk,
   input logic        rst_n,
   input logic        ctl_wr,
   input logic [1:0]  ctl_addr,
   input logic [31:0] ctl_wdata,
   input logic        bus_enable,
   input logic        bus_wait,
   input logic [AW:0] rx_words,
   input logic        armed,
   input logic        irq,
   input logic        err_ovr
);
   logic arm_wr, clr_irq_wr, clr_err_wr;
   assign arm_wr     = ctl_wr && ctl_addr == 2'd0;
   assign clr_irq_wr = ctl_wr && ctl_addr == 2'd1 && ctl_wdata[0];
   assign clr_err_wr = ctl_wr && ctl_addr == 2'd1 && ctl_wdata[1];

   p_wait_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wait == 1'b0);

   p_arm_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
      arm_wr |=> (armed && rx_words == '0));

   p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_enable && !arm_wr) |=> $stable(rx_words));

   p_done_disarms_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> !armed);

   p_irq_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !clr_irq_wr) |=> irq);

   p_unarmed_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!armed && !arm_wr) |=> $stable(rx_words));

   p_ovr_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (err_ovr && !clr_err_wr) |=> err_ovr);

   p_words_bound_r13: assert property (@(posedge clk) disable iff (!rst_n)
      rx_words <= (AW+1)'(BUF_WORDS));
endmodule

bind pbus_rx_window pbus_rx_chk #(.BUF_WORDS(BUF_WORDS)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ctl_wr     (ctl_wr),
   .ctl_addr   (ctl_addr),
   .ctl_wdata  (ctl_wdata),
   .bus_enable (bus_enable),
   .bus_wait   (bus_wait),
   .rx_words   (rx_words),
   .armed      (armed),
   .irq        (irq),
   .err_ovr    (err_ovr)
);

// File: tb/pbus_rx_window_tb.sv
`timescale 1ns/1ps
module pbus_rx_window_tb;
   localparam int DW = 16;
   localparam int BW = 64;
   localparam int AW = $clog2(BW);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ctl_wr = 1'b0;
   logic [1:0]    ctl_addr = '0;
   logic [31:0]   ctl_wdata = '0;
   logic          bus_start = 1'b0, bus_enable = 1'b0;
   logic [DW-1:0] bus_data = '0;
   logic          bus_wait;
   logic [AW-1:0] rd_addr = '0;
   logic [DW-1:0] rd_data;
   logic [AW:0]   rx_words;
   logic          armed, irq, err_ovr, err_frm;

   int n_tests = 0, n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   pbus_rx_window #(.DATA_W(DW), .BUF_WORDS(BW)) u_dut (
      .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_addr(ctl_addr),
      .ctl_wdata(ctl_wdata), .bus_start(bus_start), .bus_enable(bus_enable),
      .bus_data(bus_data), .bus_wait(bus_wait), .rd_addr(rd_addr),
      .rd_data(rd_data), .rx_words(rx_words), .armed(armed), .irq(irq),
      .err_ovr(err_ovr), .err_frm(err_frm));

   typedef struct packed {
      logic       st;
      logic       en;
      logic [15:0] d;
      logic [7:0] words;
      logic       irq;
   } vec_t;

   // window of 2 lines x 8 bytes
   localparam vec_t VEC [13] = '{
      '{1'b0, 1'b0, 16'hAAAA, 8'd0, 1'b0},  // idle (R4)
      '{1'b1, 1'b1, 16'h1001, 8'd1, 1'b0},  // line start (R3)
      '{1'b0, 1'b1, 16'h1002, 8'd2, 1'b0},
      '{1'b0, 1'b0, 16'hFFFF, 8'd2, 1'b0},  // idle mid-line (R4)
      '{1'b0, 1'b1, 16'h1003, 8'd3, 1'b0},
      '{1'b0, 1'b1, 16'h1004, 8'd4, 1'b0},  // line 1 done
      '{1'b0, 1'b1, 16'hDEAD, 8'd4, 1'b0},  // between lines, dropped (R8, R10)
      '{1'b1, 1'b0, 16'hBEEF, 8'd4, 1'b0},  // start without valid (R4)
      '{1'b1, 1'b1, 16'h2001, 8'd5, 1'b0},
      '{1'b0, 1'b1, 16'h2002, 8'd6, 1'b0},
      '{1'b0, 1'b1, 16'h2003, 8'd7, 1'b0},
      '{1'b0, 1'b1, 16'h2004, 8'd8, 1'b1},  // window done (R5, R10)
      '{1'b0, 1'b1, 16'h3333, 8'd8, 1'b1}   // unarmed, dropped (R7)
   };

   task automatic chk(input string req, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic ctl_write(input logic [1:0] a, input logic [31:0] d);
      ctl_wr = 1'b1; ctl_addr = a; ctl_wdata = d;
      @(negedge clk);
      ctl_wr = 1'b0;
   endtask

   task automatic arm_win(input int lines, input int bytes);
      ctl_write(2'd0, {lines[15:0], bytes[15:0]});
   endtask

   task automatic word(input logic st, input logic en, input logic [15:0] d);
      bus_start = st; bus_enable = en; bus_data = d;
      @(negedge clk);
      bus_start = 1'b0; bus_enable = 1'b0;
   endtask

   task automatic rd(input int a, input int exp, input string req);
      rd_addr = a[AW-1:0];
      #1;
      chk(req, int'(rd_data), exp);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 / R12 reset state
      chk("R1 irq", int'(irq), 0);
      chk("R1 armed", int'(armed), 0);
      chk("R1 err", int'({err_ovr, err_frm}), 0);
      chk("R1 words", int'(rx_words), 0);
      chk("R12 wait", int'(bus_wait), 0);

      // R2 arm
      arm_win(2, 8);
      chk("R2 armed", int'(armed), 1);
      chk("R2 words", int'(rx_words), 0);

      // table walk: R3 R4 R5 R7 R8 R10
      for (int i = 0; i < 13; i++) begin
         word(VEC[i].st, VEC[i].en, VEC[i].d);
         chk($sformatf("R3/R10 words step %0d", i), int'(rx_words), int'(VEC[i].words));
         chk($sformatf("R5 irq step %0d", i), int'(irq), int'(VEC[i].irq));
      end
      chk("R5 disarmed", int'(armed), 0);
      for (int k = 0; k < 4; k++) begin
         rd(k, 16'h1001 + k, "R3 line1 data");
         rd(k + 4, 16'h2001 + k, "R10 line2 data");
      end
      chk("R8 ovr", int'(err_ovr), 1);
      chk("R9 no frm", int'(err_frm), 0);
      chk("R12 wait", int'(bus_wait), 0);

      // R6 irq clear
      ctl_write(2'd1, 32'h0);
      chk("R6 irq held", int'(irq), 1);
      ctl_write(2'd1, 32'h1);
      chk("R6 irq cleared", int'(irq), 0);

      // R11 error clear
      ctl_write(2'd1, 32'h2);
      chk("R11 ovr cleared", int'(err_ovr), 0);

      // R7 stale words while unarmed, then fresh window
      word(1'b1, 1'b1, 16'h9999);
      chk("R7 ovr", int'(err_ovr), 1);
      chk("R7 words", int'(rx_words), 8);
      arm_win(1, 4);
      word(1'b1, 1'b1, 16'h4001);
      word(1'b0, 1'b1, 16'h4002);
      chk("R7 new irq", int'(irq), 1);
      rd(0, 16'h4001, "R7 fresh data");
      rd(1, 16'h4002, "R7 fresh data");
      ctl_write(2'd1, 32'h3);

      // R8 armed, no start
      arm_win(1, 4);
      word(1'b0, 1'b1, 16'h5555);
      chk("R8 dropped", int'(rx_words), 0);
      chk("R8 ovr", int'(err_ovr), 1);
      ctl_write(2'd1, 32'h2);

      // R9 mid-line start
      word(1'b1, 1'b1, 16'h5001);
      word(1'b1, 1'b1, 16'h6001);
      chk("R9 frm", int'(err_frm), 1);
      chk("R9 words", int'(rx_words), 1);
      rd(0, 16'h6001, "R9 rewind");
      chk("R9 no early irq", int'(irq), 0);
      word(1'b0, 1'b1, 16'h6002);
      chk("R9 irq after restart", int'(irq), 1);
      chk("R9 words final", int'(rx_words), 2);
      ctl_write(2'd1, 32'h3);

      // R13 beyond capacity: 80 words into 64
      arm_win(1, 160);
      for (int k = 0; k < 80; k++) word(k == 0, 1'b1, 16'h7000 + k);
      chk("R13 words", int'(rx_words), 64);
      chk("R13 ovr", int'(err_ovr), 1);
      chk("R13 irq", int'(irq), 1);
      rd(63, 16'h703F, "R13 last stored");

      // R2 re-arm clears count
      arm_win(1, 2);
      chk("R2 rearm armed", int'(armed), 1);
      chk("R2 rearm words", int'(rx_words), 0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule